// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block sits in the fetch stage and chooses the address to fetch next. Each cycle it receives the current fetch PC together with what decode found there: a branch kind, a signed displacement and a two-bit compiler hint. It works out the branch target and the sequential successor, picks one of them, and presents the chosen address and a taken flag from a register on the following cycle.

Jumps, calls and returns always go to the target. For conditional branches the compiler hint decides when one is present. Without a hint the rule is that backward branches are taken and forward ones are not, which suits loop-closing branches. A correction from branch resolution overrides everything else in the cycle it arrives.

Top module: `static_branch_predictor`

## Requirements
- R1: While `rst_n` is low, and until the first enabled update after it rises, `next_pc_o` equals the parameter `RESET_PC` and `taken_o` is 0.
- R2: Branch kind 2'b01 (unconditional) is always predicted taken to the target, whatever the displacement sign and the hint.
- R3: Branch kind 2'b10 (conditional) with hint 2'b00 or 2'b11 is taken when the displacement is negative. It is not taken when the displacement is zero or positive, and fetch then goes to the sequential successor.
- R4: On a conditional branch, hint 2'b10 forces a taken prediction and hint 2'b01 forces not taken, whatever the displacement sign.
- R5: Branch kind 2'b00 (no branch) and 2'b11 (reserved) give the sequential successor with `taken_o` = 0. Displacement and hint have no effect.
- R6: The target is `pc_i` plus the sign-extended `disp_i`, and the sequential successor is `pc_i` + `INSN_BYTES`. Both wrap modulo 2^`ADDR_W`.
- R7: When `redir_valid_i` is high, the next outputs are `next_pc_o` = `redir_pc_i` and `taken_o` = 0, whatever the fetch inputs are.
- R8: Outputs change at the clock edge that samples `fetch_valid_i` or `redir_valid_i` high. When both are low, `next_pc_o` and `taken_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch inputs are valid this cycle |
| pc_i | input | ADDR_W | Current fetch PC |
| kind_i | input | 2 | Branch kind: 00 none, 01 unconditional, 10 conditional, 11 reserved |
| disp_i | input | DISP_W | Signed branch displacement in bytes |
| hint_i | input | 2 | Compiler hint: 00 none, 01 likely not taken, 10 likely taken, 11 none |
| redir_valid_i | input | 1 | Branch resolution correction is valid |
| redir_pc_i | input | ADDR_W | Corrected fetch address |
| next_pc_o | output | ADDR_W | Predicted next fetch address (registered) |
| taken_o | output | 1 | Prediction went to the branch target (registered) |

## Verification
The bench builds the block with `ADDR_W` = 16 and `DISP_W` = 12, and sets `RESET_PC` to 16'h0100 so that the reset value differs from zero. With a 16-bit address, the wrap of both the sequential successor and the target past the top of the address space can be reached with a few directed PCs near 16'hFFFC and 16'h0000. A 12-bit displacement keeps the sign extension over four upper bits in play, with the extremes −2048 and +2047. Random cycles then mix every kind, hint, redirect and idle combination against the same reference model.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;
  typedef enum logic [1:0] {
    KIND_NONE   = 2'b00,
    KIND_UNCOND = 2'b01,
    KIND_COND   = 2'b10,
    KIND_RSVD   = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    HINT_NONE  = 2'b00,
    HINT_NOT   = 2'b01,
    HINT_TAKEN = 2'b10,
    HINT_RSVD  = 2'b11
  } br_hint_e;
endpackage

// File: rtl/sbp_target_calc.sv
`timescale 1ns/1ps
module sbp_target_calc #(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] fallthru_o,
  output logic              disp_neg_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_noext
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  assign disp_neg_o = disp_i[DISP_W-1];
  assign target_o   = pc_i + disp_ext;
  assign fallthru_o = pc_i + ADDR_W'(INSN_BYTES);
endmodule

// File: rtl/sbp_direction.sv
`timescale 1ns/1ps
module sbp_direction
  import sbp_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic [1:0] hint_i,
  input  logic       disp_neg_i,
  output logic       taken_o
);
  br_kind_e kind;
  br_hint_e hint;

  assign kind = br_kind_e'(kind_i);
  assign hint = br_hint_e'(hint_i);

  always_comb begin
    taken_o = 1'b0;
    case (kind)
      KIND_UNCOND: taken_o = 1'b1;
      KIND_COND: begin
        case (hint)
          HINT_TAKEN: taken_o = 1'b1;
          HINT_NOT:   taken_o = 1'b0;
          default:    taken_o = disp_neg_i;
        endcase
      end
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sbp_out_reg.sv
`timescale 1ns/1ps
module sbp_out_reg #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] pc_d,
  input  logic              taken_d,
  output logic [ADDR_W-1:0] pc_q,
  output logic              taken_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      taken_q <= 1'b0;
    end else if (en_i) begin
      pc_q    <= pc_d;
      taken_q <= taken_d;
    end
  end
endmodule

// File: rtl/static_branch_predictor.sv
`timescale 1ns/1ps
module static_branch_predictor
  import sbp_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DISP_W     = 16,
  parameter int                INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [1:0]        kind_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        hint_i,
  input  logic              redir_valid_i,
  input  logic [ADDR_W-1:0] redir_pc_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o
);
  logic [ADDR_W-1:0] target, fallthru, pc_d;
  logic              disp_neg, pred_taken, taken_d, upd_en;

  sbp_target_calc #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .INSN_BYTES(INSN_BYTES)
  ) u_tgt (
    .pc_i(pc_i), .disp_i(disp_i), .target_o(target),
    .fallthru_o(fallthru), .disp_neg_o(disp_neg)
  );

  sbp_direction u_dir (
    .kind_i(kind_i), .hint_i(hint_i), .disp_neg_i(disp_neg), .taken_o(pred_taken)
  );

  // next-state selection: resolution correction wins over any prediction
  always_comb begin
    upd_en  = fetch_valid_i | redir_valid_i;
    pc_d    = next_pc_o;
    taken_d = taken_o;
    if (redir_valid_i) begin
      pc_d    = redir_pc_i;
      taken_d = 1'b0;
    end else if (fetch_valid_i) begin
      pc_d    = pred_taken ? target : fallthru;
      taken_d = pred_taken;
    end
  end

  sbp_out_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_reg (
    .clk(clk), .rst_n(rst_n), .en_i(upd_en), .pc_d(pc_d), .taken_d(taken_d),
    .pc_q(next_pc_o), .taken_q(taken_o)
  );

  // R2: unconditional branches always go to the target
  a_r2_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && !redir_valid_i && kind_i == 2'b01)
      |=> (taken_o && next_pc_o == $past(target)));

  // R3: unhinted forward conditional falls through
  a_r3_fwd_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && !redir_valid_i && kind_i == 2'b10 &&
     (hint_i == 2'b00 || hint_i == 2'b11) && !disp_i[DISP_W-1])
      |=> (!taken_o && next_pc_o == $past(pc_i) + ADDR_W'(INSN_BYTES)));

  // R4: likely-taken hint wins over a forward displacement
  a_r4_hint_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && !redir_valid_i && kind_i == 2'b10 && hint_i == 2'b10)
      |=> taken_o);

  // R5: no branch never predicts taken
  a_r5_nobranch: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && !redir_valid_i && (kind_i == 2'b00 || kind_i == 2'b11))
      |=> (!taken_o && next_pc_o == $past(pc_i) + ADDR_W'(INSN_BYTES)));

  // R7: correction overrides prediction
  a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_i |=> (!taken_o && next_pc_o == $past(redir_pc_i)));

  // R8: outputs hold when idle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid_i && !redir_valid_i) |=> ($stable(next_pc_o) && $stable(taken_o)));
endmodule

// File: tb/tb_static_branch_predictor.sv
`timescale 1ns/1ps
module tb_static_branch_predictor;
  localparam int          AW  = 16;
  localparam int          DW  = 12;
  localparam logic [15:0] RPC = 16'h0100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid_i, redir_valid_i, taken_o;
  logic [AW-1:0] pc_i, redir_pc_i, next_pc_o;
  logic [1:0]    kind_i, hint_i;
  logic [DW-1:0] disp_i;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] exp_pc;
  logic          exp_tk;

  always #2.5 clk = ~clk;

  static_branch_predictor #(
    .ADDR_W(AW), .DISP_W(DW), .INSN_BYTES(4), .RESET_PC(RPC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid_i), .pc_i(pc_i),
    .kind_i(kind_i), .disp_i(disp_i), .hint_i(hint_i),
    .redir_valid_i(redir_valid_i), .redir_pc_i(redir_pc_i),
    .next_pc_o(next_pc_o), .taken_o(taken_o)
  );

  task automatic check(input string req);
    checks++;
    if (next_pc_o !== exp_pc || taken_o !== exp_tk) begin
      failures++;
      $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
               req, next_pc_o, taken_o, exp_pc, exp_tk);
    end
  endtask

  // reference model: behavioural rules on integers
  task automatic step(input logic fv, input logic [1:0] k, input int pc, input int disp,
                      input logic [1:0] h, input logic rv, input int rpc, input string req);
    logic tk;
    fetch_valid_i = fv; kind_i = k; pc_i = AW'(pc); disp_i = DW'(disp);
    hint_i = h; redir_valid_i = rv; redir_pc_i = AW'(rpc);
    if (rv) begin
      exp_pc = AW'(rpc); exp_tk = 1'b0;
    end else if (fv) begin
      if (k == 2'b01) tk = 1'b1;
      else if (k == 2'b10) tk = (h == 2'b10) ? 1'b1 : (h == 2'b01) ? 1'b0 : (disp < 0);
      else tk = 1'b0;
      exp_tk = tk;
      exp_pc = tk ? AW'((pc + disp) & 32'hFFFF) : AW'((pc + 4) & 32'hFFFF);
    end
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_valid_i = 1'b1; kind_i = 2'b01; pc_i = 16'h2000;
    disp_i = 12'h010; hint_i = 2'b00; redir_valid_i = 1'b0; redir_pc_i = '0;
    exp_pc = RPC; exp_tk = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    fetch_valid_i = 1'b0;
    @(negedge clk);
    check("R1 after release idle");

    step(1, 2'b01, 'h1000, 64, 2'b00, 0, 0, "R2 uncond fwd");
    step(1, 2'b01, 'h1000, -64, 2'b01, 0, 0, "R2 uncond back with not-taken hint");
    step(1, 2'b10, 'h1000, -16, 2'b00, 0, 0, "R3 cond backward");
    step(1, 2'b10, 'h1000, 16, 2'b00, 0, 0, "R3 cond forward");
    step(1, 2'b10, 'h1000, 0, 2'b00, 0, 0, "R3 cond zero disp");
    step(1, 2'b10, 'h1000, -2048, 2'b11, 0, 0, "R3 hint 11 backward min");
    step(1, 2'b10, 'h1000, 2047, 2'b11, 0, 0, "R3 hint 11 forward max");
    step(1, 2'b10, 'h1000, 40, 2'b10, 0, 0, "R4 likely taken forward");
    step(1, 2'b10, 'h1000, -40, 2'b01, 0, 0, "R4 likely not taken backward");
    step(1, 2'b00, 'h1000, -40, 2'b10, 0, 0, "R5 none ignores hint");
    step(1, 2'b11, 'h1000, -8, 2'b10, 0, 0, "R5 reserved kind");
    step(1, 2'b10, 'hFFFC, 12, 2'b00, 0, 0, "R6 fallthrough wrap");
    step(1, 2'b01, 'hFFF0, 32, 2'b00, 0, 0, "R6 target wrap up");
    step(1, 2'b10, 'h0004, -8, 2'b00, 0, 0, "R6 target wrap down");
    step(1, 2'b01, 'h1000, 64, 2'b00, 1, 'h3456, "R7 redirect over uncond");
    step(0, 2'b00, 0, 0, 2'b00, 1, 'h0ABC, "R7 redirect alone");
    step(1, 2'b01, 'h2000, 8, 2'b00, 0, 0, "R8 set taken");
    step(0, 2'b10, 'h3000, -4, 2'b10, 0, 0, "R8 idle holds");
    step(0, 2'b00, 'h5000, 4, 2'b00, 0, 0, "R8 idle holds again");

    for (int i = 0; i < 400; i++) begin
      int d;
      d = int'($urandom_range(4095)) - 2048;
      step(($urandom_range(3) != 0), 2'($urandom_range(3)), int'($urandom_range(65535)) & 'hFFFC,
           d, 2'($urandom_range(3)), ($urandom_range(7) == 0),
           int'($urandom_range(65535)) & 'hFFFC, "R6 random mix");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule